// File: doc/BRIEF.md
# Multi-Queue Write Port Switcher

This block is the write-side controller of a FIFO array that holds many logical queues. A write-address strobe together with an 8-bit write address picks the queue that following writes go to. The seven low address bits name one of 128 queues. The top bit is compared with a static one-bit chip identifier, so that two devices can sit in a single 256-queue address space and only the addressed one takes part.

A queue change runs as a fixed four-edge sequence. On the strobe edge and on the edge after it, writes still land in the old queue. On the third edge nothing is written and the active-low full flag switches to the new queue's status. From the fourth edge on, writes go to the new queue. A write is issued to the storage side, which is outside this block, as a registered strobe with a queue index and data. It is never issued to a queue that reports full.

Top module: `mq_wr_switch`

## Requirements
- R1: After reset, `st_we` is 0, `full_oe` is 0 and `full_n` is 1. The device stays unselected until a strobe with a matching address MSB is accepted.
- R2: A strobe accepted on edge E with `wadr[7] == chip_id` makes queue `wadr[6:0]` active. Writes with `wen_n` low reach that queue from edge E+3 on, shown by `st_we=1` and `st_q=wadr[6:0]`.
- R3: On edges E and E+1, a write with `wen_n` low goes to the previously active queue. With `wen_n` high on those edges, no write is issued.
- R4: On edge E+2, no write is issued whatever `wen_n` is. On that edge, `full_n` takes the value `~q_full[new queue]`.
- R5: A write whose target queue has `q_full` bit 1 is blocked (`st_we=0`).
- R6: A strobe on edges E+1 to E+3 of a running change is ignored. The change under way completes and later writes keep going to its queue.
- R7: A strobe whose `wadr[7]` differs from `chip_id` leaves the active queue as it was. From edge E+2 on, the device is deselected: `full_oe=0` and no writes are issued. `full_n` keeps following the retained queue.
- R8: Outside edge E+2, `full_n` follows `~q_full` of the active queue on each edge. `full_oe` is high only while the device is selected, and writes happen only while it is selected.
- R9: All outputs are registered. `st_d` carries the `din` value sampled on the same edge that raised `st_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_id | input | 1 | Static device identifier compared with the address MSB |
| wadr_stb | input | 1 | Queue-change strobe, active high |
| wadr | input | 8 | Write address: MSB device select, low 7 bits queue |
| wen_n | input | 1 | Write enable, active low |
| din | input | 36 | Write data |
| q_full | input | 128 | Per-queue full status from storage, 1 = full |
| st_we | output | 1 | Registered write strobe to storage |
| st_q | output | 7 | Queue index of the write |
| st_d | output | 36 | Write data to storage |
| full_n | output | 1 | Active-low full flag of the active queue |
| full_oe | output | 1 | Drive enable of the full flag, high when selected |

## Verification
The hardest case to reach is a strobe that arrives in the middle of a running change, combined with the trailing writes to the old queue. The ignored strobe must not corrupt the pending queue, and the old queue must still receive the two trailing words. The directed stimulus sends a second strobe on the edge after the first, with an address that would be legal. It then checks the queue index of every write across the four edges and after them. A second hard case is the deselect path, where the retained queue cannot be seen through writes. To reach it, the stimulus flips that queue's full status while the flag driver is released and watches `full_n` move.

// File: rtl/mq_wr_pkg.sv
package mq_wr_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_OLD  = 2'd1,
    PH_FLAG = 2'd2,
    PH_NEW  = 2'd3
  } phase_t;
endpackage

// File: rtl/mq_wr_seq.sv
module mq_wr_seq
  import mq_wr_pkg::*;
#(
  parameter int ADDR_W = 8,
  localparam int QW = ADDR_W - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chip_id,
  input  logic          stb,
  input  logic [ADDR_W-1:0] adr,
  output phase_t        phase,
  output logic [QW-1:0] active_q,
  output logic          sel,
  output logic [QW-1:0] flag_q,
  output logic          sel_nxt
);
  logic [QW-1:0] pend_q;
  logic          pend_hit;
  logic          accept;

  assign accept = (phase == PH_IDLE) && stb;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      active_q <= '0;
      sel      <= 1'b0;
      pend_q   <= '0;
      pend_hit <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: if (accept) begin
          phase    <= PH_OLD;
          pend_q   <= adr[QW-1:0];
          pend_hit <= (adr[ADDR_W-1] == chip_id);
        end
        PH_OLD:  phase <= PH_FLAG;
        PH_FLAG: begin
          phase <= PH_NEW;
          sel   <= pend_hit;
          if (pend_hit) active_q <= pend_q;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign flag_q  = (phase == PH_FLAG && pend_hit) ? pend_q : active_q;
  assign sel_nxt = (phase == PH_FLAG) ? pend_hit : sel;

  a_r6_old_to_flag: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_OLD) |=> (phase == PH_FLAG));
  a_r6_flag_to_new: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FLAG) |=> (phase == PH_NEW));
  a_r6_new_to_idle: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_NEW) |=> (phase == PH_IDLE));
  a_r7_mismatch_keeps_queue: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FLAG && !pend_hit) |=> $stable(active_q));
endmodule

// File: rtl/mq_wr_issue.sv
module mq_wr_issue
  import mq_wr_pkg::*;
#(
  parameter int QW     = 7,
  parameter int DATA_W = 36,
  localparam int NQ = 1 << QW
) (
  input  logic              clk,
  input  logic              rst,
  input  phase_t            phase,
  input  logic              sel,
  input  logic [QW-1:0]     active_q,
  input  logic              wen_n,
  input  logic [DATA_W-1:0] din,
  input  logic [NQ-1:0]     q_full,
  output logic              st_we,
  output logic [QW-1:0]     st_q,
  output logic [DATA_W-1:0] st_d
);
  logic go;

  assign go = sel && !wen_n && (phase != PH_FLAG) && !q_full[active_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_we <= 1'b0;
      st_q  <= '0;
      st_d  <= '0;
    end else begin
      st_we <= go;
      if (go) begin
        st_q <= active_q;
        st_d <= din;
      end
    end
  end

  a_r4_no_write_flag_cycle: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FLAG) |=> !st_we);
  a_r3_write_needs_enable: assert property (@(posedge clk) disable iff (rst)
    st_we |-> $past(!wen_n));
  a_r8_write_needs_select: assert property (@(posedge clk) disable iff (rst)
    st_we |-> $past(sel));
endmodule

// File: rtl/mq_wr_flag.sv
module mq_wr_flag #(
  parameter int QW = 7,
  localparam int NQ = 1 << QW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [QW-1:0] flag_q,
  input  logic          sel_nxt,
  input  logic [NQ-1:0] q_full,
  output logic          full_n,
  output logic          full_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full_n  <= 1'b1;
      full_oe <= 1'b0;
    end else begin
      full_n  <= ~q_full[flag_q];
      full_oe <= sel_nxt;
    end
  end

  a_r1_oe_low_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> !full_oe);
endmodule

// File: rtl/mq_wr_switch.sv
module mq_wr_switch
  import mq_wr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 36,
  localparam int QW = ADDR_W - 1,
  localparam int NQ = 1 << QW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chip_id,
  input  logic              wadr_stb,
  input  logic [ADDR_W-1:0] wadr,
  input  logic              wen_n,
  input  logic [DATA_W-1:0] din,
  input  logic [NQ-1:0]     q_full,
  output logic              st_we,
  output logic [QW-1:0]     st_q,
  output logic [DATA_W-1:0] st_d,
  output logic              full_n,
  output logic              full_oe
);
  phase_t        phase;
  logic [QW-1:0] active_q;
  logic          sel;
  logic [QW-1:0] flag_q;
  logic          sel_nxt;

  mq_wr_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst), .chip_id(chip_id), .stb(wadr_stb), .adr(wadr),
    .phase(phase), .active_q(active_q), .sel(sel),
    .flag_q(flag_q), .sel_nxt(sel_nxt)
  );

  mq_wr_issue #(.QW(QW), .DATA_W(DATA_W)) u_issue (
    .clk(clk), .rst(rst), .phase(phase), .sel(sel), .active_q(active_q),
    .wen_n(wen_n), .din(din), .q_full(q_full),
    .st_we(st_we), .st_q(st_q), .st_d(st_d)
  );

  mq_wr_flag #(.QW(QW)) u_flag (
    .clk(clk), .rst(rst), .flag_q(flag_q), .sel_nxt(sel_nxt),
    .q_full(q_full), .full_n(full_n), .full_oe(full_oe)
  );

  a_r8_write_while_driving: assert property (@(posedge clk) disable iff (rst)
    st_we |-> $past(full_oe));
endmodule

// File: tb/mq_wr_switch_tb.sv
module mq_wr_switch_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         chip_id = 1'b1;
  logic         wadr_stb = 1'b0;
  logic [7:0]   wadr = '0;
  logic         wen_n = 1'b1;
  logic [35:0]  din = '0;
  logic [127:0] q_full = '0;
  logic         st_we;
  logic [6:0]   st_q;
  logic [35:0]  st_d;
  logic         full_n, full_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mq_wr_switch u_dut (
    .clk(clk), .rst(rst), .chip_id(chip_id), .wadr_stb(wadr_stb), .wadr(wadr),
    .wen_n(wen_n), .din(din), .q_full(q_full),
    .st_we(st_we), .st_q(st_q), .st_d(st_d),
    .full_n(full_n), .full_oe(full_oe)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive at negedge, pass one rising edge, return at the next negedge
  task automatic tick(input bit stb, input logic [7:0] a, input bit wn, input logic [35:0] d);
    wadr_stb = stb; wadr = a; wen_n = wn; din = d;
    @(posedge clk);
    @(negedge clk);
    wadr_stb = 1'b0;
  endtask

  task automatic exp_wr(input string tag, input bit we, input int q, input logic [35:0] d);
    chk(st_we == we, {tag, " st_we"}, st_we, we);
    if (we) begin
      chk(st_q == q[6:0], {tag, " st_q"}, st_q, q);
      chk(st_d == d, {tag, " st_d"}, st_d, d);
    end
  endtask

  task automatic t_reset;
    chk(st_we == 1'b0, "R1 reset st_we", st_we, 0);
    chk(full_oe == 1'b0, "R1 reset full_oe", full_oe, 0);
    chk(full_n == 1'b1, "R1 reset full_n", full_n, 1);
    tick(0, 8'h00, 0, 36'h1);
    exp_wr("R1 unselected write", 0, 0, 0);
  endtask

  task automatic t_first_select;
    tick(1, 8'h85, 0, 36'hA0);
    exp_wr("R8 strobe edge unselected", 0, 0, 0);
    tick(0, 8'h00, 0, 36'hA1);
    exp_wr("R8 edge2 unselected", 0, 0, 0);
    tick(0, 8'h00, 0, 36'hA2);
    exp_wr("R4 flag edge", 0, 0, 0);
    chk(full_oe == 1'b1, "R8 oe after select", full_oe, 1);
    chk(full_n == 1'b1, "R4 full_n new q5", full_n, 1);
    tick(0, 8'h00, 0, 36'hA3);
    exp_wr("R2 first write q5", 1, 5, 36'hA3);
  endtask

  task automatic t_idle_writes;
    tick(0, 8'h00, 1, 36'hB0);
    exp_wr("R3 idle wen high", 0, 0, 0);
    tick(0, 8'h00, 0, 36'hB1);
    exp_wr("R9 idle data", 1, 5, 36'hB1);
    q_full[5] = 1'b1;
    tick(0, 8'h00, 0, 36'hB2);
    exp_wr("R5 full blocks", 0, 0, 0);
    chk(full_n == 1'b0, "R8 full_n tracks q5", full_n, 0);
    q_full[5] = 1'b0;
    tick(0, 8'h00, 1, 36'hB3);
    chk(full_n == 1'b1, "R8 full_n clears", full_n, 1);
  endtask

  task automatic t_change_to_full;
    q_full[9] = 1'b1;
    tick(1, 8'h89, 0, 36'hC0);
    exp_wr("R3 trailing 1 old q", 1, 5, 36'hC0);
    chk(full_n == 1'b1, "R4 flag still old", full_n, 1);
    tick(0, 8'h00, 0, 36'hC1);
    exp_wr("R3 trailing 2 old q", 1, 5, 36'hC1);
    tick(0, 8'h00, 0, 36'hC2);
    exp_wr("R4 no write edge3", 0, 0, 0);
    chk(full_n == 1'b0, "R4 full_n new q9", full_n, 0);
    tick(0, 8'h00, 0, 36'hC3);
    exp_wr("R5 new queue full", 0, 0, 0);
    q_full[9] = 1'b0;
    tick(0, 8'h00, 0, 36'hC4);
    exp_wr("R2 write q9", 1, 9, 36'hC4);
  endtask

  task automatic t_trailing_disabled;
    tick(1, 8'h8C, 1, 36'hD0);
    exp_wr("R3 trailing wen high 1", 0, 0, 0);
    tick(0, 8'h00, 1, 36'hD1);
    exp_wr("R3 trailing wen high 2", 0, 0, 0);
    tick(0, 8'h00, 1, 36'hD2);
    tick(0, 8'h00, 0, 36'hD3);
    exp_wr("R2 write q12", 1, 12, 36'hD3);
  endtask

  task automatic t_busy_strobe;
    tick(1, 8'h94, 0, 36'hE0);
    exp_wr("R3 busy old 1", 1, 12, 36'hE0);
    tick(1, 8'h83, 0, 36'hE1);
    exp_wr("R6 second strobe old", 1, 12, 36'hE1);
    tick(1, 8'h84, 0, 36'hE2);
    exp_wr("R4 busy flag edge", 0, 0, 0);
    tick(1, 8'h86, 0, 36'hE3);
    exp_wr("R6 write q20", 1, 20, 36'hE3);
    tick(0, 8'h00, 0, 36'hE4);
    exp_wr("R6 stays q20", 1, 20, 36'hE4);
  endtask

  task automatic t_mismatch;
    q_full[3] = 1'b1;
    tick(1, 8'h03, 0, 36'hF0);
    exp_wr("R7 trailing old 1", 1, 20, 36'hF0);
    tick(0, 8'h00, 0, 36'hF1);
    exp_wr("R7 trailing old 2", 1, 20, 36'hF1);
    tick(0, 8'h00, 0, 36'hF2);
    chk(full_oe == 1'b0, "R7 deselected oe", full_oe, 0);
    chk(full_n == 1'b1, "R7 full_n retained q20", full_n, 1);
    tick(0, 8'h00, 0, 36'hF3);
    exp_wr("R7 no write deselected", 0, 0, 0);
    q_full[20] = 1'b1;
    tick(0, 8'h00, 0, 36'hF4);
    chk(full_n == 1'b0, "R7 full_n follows q20", full_n, 0);
    exp_wr("R7 still no write", 0, 0, 0);
    q_full[20] = 1'b0;
    tick(1, 8'h83, 0, 36'hF5);
    tick(0, 8'h00, 0, 36'hF6);
    tick(0, 8'h00, 0, 36'hF7);
    chk(full_oe == 1'b1, "R2 reselect oe", full_oe, 1);
    chk(full_n == 1'b0, "R4 full_n q3 full", full_n, 0);
    tick(0, 8'h00, 0, 36'hF8);
    exp_wr("R5 q3 full blocks", 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_first_select;
    t_idle_writes;
    t_change_to_full;
    t_trailing_disabled;
    t_busy_strobe;
    t_mismatch;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule